// File: doc/BRIEF.md
# Banked Control Register File for a Multi-Channel Descriptor DMA

This block is the register file that software uses to steer a multi-channel descriptor DMA engine. A plain 32-bit bus with address, write strobe, write data and a combinational read return reaches a small set of global registers. These are an identification word, an engine-wide soft reset, a channel pointer, a port pointer and an interrupt mask with one bit per channel. A window of per-channel registers shows the bank chosen by the channel pointer, and a single port-configuration register shows the bank chosen by the port pointer.

Each channel bank holds the on/off state, transfer direction, arbitration weight, descriptor ring base, ring length, polling settings, a six-bit event status and its enable. A channel reset request is self-clearing: it stays visible for a fixed number of cycles, then clears that channel's run state, events and ring index. The engine side feeds event pulses and descriptor-advance strobes in. The block returns the run and direction state, the current ring index of each channel, and one combined interrupt line.

Top module: `dmac_regfile`

## Requirements
- R1: Reading offset 0x08 returns the read-only ID word: channel count in bits 26:20, port count in bits 19:16, revision in bits 4:0, all other bits zero (0x00420003 with default parameters). Writes to it change nothing.
- R2: Offset 0x18 holds the channel pointer. Offsets 0x14, 0x1C, 0x20, 0x24, 0x28 and 0x2C reach only the bank of the pointed channel. If the pointer is at or beyond the channel count, those offsets read zero and writes to them are dropped.
- R3: Channel control at 0x1C stores run (bit 0), transmit direction (bit 8) and weight (bits 17:16), reads them back in place, and drives `ch_on` and `ch_tx` for that channel.
- R4: Writing bit 1 of channel control starts a channel reset. Bit 1 reads 1 for exactly 4 cycles after the write edge and then 0. Completion clears that channel's run bit, event status and ring index and leaves other channels untouched.
- R5: Status at 0x28 keeps event bits 6:1. Bit k of a channel's `stat_set` slice sets status bit k+1. Writing a 1 clears a bit, so 0x7E clears all of them. A set pulse in the same cycle as a clearing write wins.
- R6: `irq` is high exactly when some channel n has a status bit also set in its enable register at 0x2C (bit 3 is the descriptor-complete enable) and has bit n set in the mask at 0xF4.
- R7: Offset 0x40 holds the port pointer. Port control at 0x44 keeps receive burst (bits 3:2), transmit burst (bits 5:4), drop enable (bit 6) and swap select (bits 11:8) per port, reading other bits as zero. Burst codes are 1, 2 and 3 for 2, 4 and 8 words.
- R8: The poll register at 0x14 keeps only bit 31 (polling on) and bit 6 (divide-by-4 poll clock). All other bits read zero.
- R9: Writing 1 to bit 0 of global control at 0x10 returns every register of every bank, both pointers and the mask to their reset values. Global control always reads zero.
- R10: Any offset not listed above reads zero, and writes to it change no register.
- R11: A `desc_step` strobe advances that channel's `desc_idx` by one, wrapping to 0 when the next value would reach the ring length at 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| stat_set | input | NCH*6 | Event pulses, channel n in bits n*6+5:n*6 |
| desc_step | input | NCH | Ring-advance strobe per channel |
| ch_on | output | NCH | Channel run state |
| ch_tx | output | NCH | Channel transmit direction |
| desc_idx | output | NCH*LEN_W | Current ring index, channel n at n*LEN_W |
| irq | output | 1 | Combined masked interrupt |

## Verification
The banking is driven with different values written into two channels and two ports, then read back in alternating order, which exposes crosstalk between banks and an out-of-range pointer that still reaches a bank. The event logic gets single pulses, partial and full clearing masks, and a pulse that coincides with a clear. This separates write-one-to-clear from plain write and shows which side wins. The interrupt line is tried under each combination of status, enable and mask bits, so an ungated or wrong-channel path shows up. Channel reset is timed cycle by cycle against a neighbouring running channel, and ring indices are stepped through a wrap.

// File: rtl/dmac_rf_pkg.sv
package dmac_rf_pkg;

   localparam logic [7:0] OFF_ID   = 8'h08;
   localparam logic [7:0] OFF_GCTL = 8'h10;
   localparam logic [7:0] OFF_POLL = 8'h14;
   localparam logic [7:0] OFF_CSEL = 8'h18;
   localparam logic [7:0] OFF_CTRL = 8'h1C;
   localparam logic [7:0] OFF_BASE = 8'h20;
   localparam logic [7:0] OFF_LEN  = 8'h24;
   localparam logic [7:0] OFF_STAT = 8'h28;
   localparam logic [7:0] OFF_IE   = 8'h2C;
   localparam logic [7:0] OFF_PSEL = 8'h40;
   localparam logic [7:0] OFF_PCTL = 8'h44;
   localparam logic [7:0] OFF_MASK = 8'hF4;

   typedef enum logic [3:0] {
      RK_NONE, RK_ID, RK_GCTL, RK_POLL, RK_CSEL, RK_CTRL, RK_BASE,
      RK_LEN, RK_STAT, RK_IE, RK_PSEL, RK_PCTL, RK_MASK
   } reg_kind_e;

   typedef struct packed {
      logic [1:0] weight;
      logic       tx;
      logic       on;
   } chan_ctrl_t;

   typedef struct packed {
      logic [3:0] swap;
      logic       drop;
      logic [1:0] tx_burst;
      logic [1:0] rx_burst;
   } port_cfg_t;

   function automatic reg_kind_e decode_off(input logic [7:0] off);
      case (off)
         OFF_ID:   return RK_ID;
         OFF_GCTL: return RK_GCTL;
         OFF_POLL: return RK_POLL;
         OFF_CSEL: return RK_CSEL;
         OFF_CTRL: return RK_CTRL;
         OFF_BASE: return RK_BASE;
         OFF_LEN:  return RK_LEN;
         OFF_STAT: return RK_STAT;
         OFF_IE:   return RK_IE;
         OFF_PSEL: return RK_PSEL;
         OFF_PCTL: return RK_PCTL;
         OFF_MASK: return RK_MASK;
         default:  return RK_NONE;
      endcase
   endfunction

   function automatic logic is_chan_kind(input reg_kind_e k);
      return (k == RK_POLL) || (k == RK_CTRL) || (k == RK_BASE) ||
             (k == RK_LEN)  || (k == RK_STAT) || (k == RK_IE);
   endfunction

endpackage

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
   import dmac_rf_pkg::*;
#(
   parameter int LEN_W    = 8,
   parameter int RST_CYC  = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             wr,
   input  reg_kind_e        kind,
   input  logic [31:0]      wdata,
   input  logic [5:0]       set_pulse,
   input  logic             step,
   output logic [31:0]      rdata,
   output logic             on,
   output logic             tx,
   output logic [LEN_W-1:0] idx,
   output logic             int_req
);

   localparam int CNT_W = $clog2(RST_CYC + 1);

   chan_ctrl_t       ctrl_q;
   logic [CNT_W-1:0] rcnt_q;
   logic [31:0]      base_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] idx_q;
   logic             poll_en_q;
   logic             poll_div_q;
   logic [5:0]       stat_q;
   logic [5:0]       ie_q;

   logic             busy;
   logic             done;
   logic             wr_ctrl;
   logic [5:0]       clr_mask;
   logic [5:0]       stat_nx;
   logic [LEN_W:0]   idx_inc;

   assign busy     = (rcnt_q != '0);
   assign done     = (rcnt_q == CNT_W'(1));
   assign wr_ctrl  = wr && (kind == RK_CTRL);
   assign clr_mask = (wr && (kind == RK_STAT)) ? wdata[6:1] : 6'd0;
   assign idx_inc  = {1'b0, idx_q} + (LEN_W+1)'(1);

   generate
      if (SET_WINS) begin : g_set_wins
         assign stat_nx = (stat_q & ~clr_mask) | set_pulse;
      end else begin : g_clr_wins
         assign stat_nx = (stat_q | set_pulse) & ~clr_mask;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         rcnt_q     <= '0;
         base_q     <= '0;
         len_q      <= '0;
         idx_q      <= '0;
         poll_en_q  <= 1'b0;
         poll_div_q <= 1'b0;
         stat_q     <= '0;
         ie_q       <= '0;
      end else if (soft_rst) begin
         ctrl_q     <= '0;
         rcnt_q     <= '0;
         base_q     <= '0;
         len_q      <= '0;
         idx_q      <= '0;
         poll_en_q  <= 1'b0;
         poll_div_q <= 1'b0;
         stat_q     <= '0;
         ie_q       <= '0;
      end else begin
         if (wr_ctrl && wdata[1]) begin
            rcnt_q <= CNT_W'(RST_CYC);
         end else if (busy) begin
            rcnt_q <= rcnt_q - CNT_W'(1);
         end

         if (done) begin
            ctrl_q.on <= 1'b0;
         end
         if (wr_ctrl) begin
            ctrl_q.on     <= wdata[0];
            ctrl_q.tx     <= wdata[8];
            ctrl_q.weight <= wdata[17:16];
         end

         stat_q <= done ? 6'd0 : stat_nx;

         if (done) begin
            idx_q <= '0;
         end else if (step) begin
            idx_q <= (idx_inc >= {1'b0, len_q}) ? '0 : idx_inc[LEN_W-1:0];
         end

         if (wr && (kind == RK_BASE)) base_q <= wdata;
         if (wr && (kind == RK_LEN))  len_q  <= wdata[LEN_W-1:0];
         if (wr && (kind == RK_IE))   ie_q   <= wdata[6:1];
         if (wr && (kind == RK_POLL)) begin
            poll_en_q  <= wdata[31];
            poll_div_q <= wdata[6];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (kind)
         RK_CTRL: begin
            rdata[0]     = ctrl_q.on;
            rdata[1]     = busy;
            rdata[8]     = ctrl_q.tx;
            rdata[17:16] = ctrl_q.weight;
         end
         RK_POLL: begin
            rdata[31] = poll_en_q;
            rdata[6]  = poll_div_q;
         end
         RK_BASE: rdata              = base_q;
         RK_LEN:  rdata[LEN_W-1:0]   = len_q;
         RK_STAT: rdata[6:1]         = stat_q;
         RK_IE:   rdata[6:1]         = ie_q;
         default: rdata              = '0;
      endcase
   end

   assign on      = ctrl_q.on;
   assign tx      = ctrl_q.tx;
   assign idx     = idx_q;
   assign int_req = |(stat_q & ie_q);

endmodule

// File: rtl/dmac_port_bank.sv
module dmac_port_bank
   import dmac_rf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        soft_rst,
   input  logic        wr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata
);

   port_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (soft_rst) begin
         cfg_q <= '0;
      end else if (wr) begin
         cfg_q.rx_burst <= wdata[3:2];
         cfg_q.tx_burst <= wdata[5:4];
         cfg_q.drop     <= wdata[6];
         cfg_q.swap     <= wdata[11:8];
      end
   end

   always_comb begin
      rdata        = '0;
      rdata[3:2]   = cfg_q.rx_burst;
      rdata[5:4]   = cfg_q.tx_burst;
      rdata[6]     = cfg_q.drop;
      rdata[11:8]  = cfg_q.swap;
   end

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
   import dmac_rf_pkg::*;
#(
   parameter int       ADDR_W   = 8,
   parameter int       NCH      = 4,
   parameter int       NPORT    = 2,
   parameter int       LEN_W    = 8,
   parameter int       RST_CYC  = 4,
   parameter bit [4:0] REV      = 5'h03,
   parameter bit       SET_WINS = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   bus_we,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   input  logic [NCH*6-1:0]       stat_set,
   input  logic [NCH-1:0]         desc_step,
   output logic [NCH-1:0]         ch_on,
   output logic [NCH-1:0]         ch_tx,
   output logic [NCH*LEN_W-1:0]   desc_idx,
   output logic                   irq
);

   localparam int CSEL_W = 7;
   localparam int PSEL_W = 4;
   localparam logic [31:0] ID_WORD =
      {5'd0, 7'(NCH), 4'(NPORT), 11'd0, REV};

   generate
      if (ADDR_W < 8)               begin : g_bad_addr  $error("ADDR_W below 8");       end
      if (NCH < 1 || NCH > 127)     begin : g_bad_nch   $error("NCH out of 1..127");    end
      if (NPORT < 1 || NPORT > 15)  begin : g_bad_nport $error("NPORT out of 1..15");   end
      if (LEN_W < 1 || LEN_W > 32)  begin : g_bad_len   $error("LEN_W out of 1..32");   end
      if (RST_CYC < 1)              begin : g_bad_rst   $error("RST_CYC below 1");      end
   endgenerate

   reg_kind_e          kind;
   logic               soft_rst;
   logic [CSEL_W-1:0]  csel_q;
   logic [PSEL_W-1:0]  psel_q;
   logic [NCH-1:0]     mask_q;
   logic [31:0]        chan_rd [NCH];
   logic [31:0]        port_rd [NPORT];
   logic [NCH-1:0]     chan_int;

   always_comb begin
      if (|(bus_addr >> 8)) kind = RK_NONE;
      else                  kind = decode_off(bus_addr[7:0]);
   end

   assign soft_rst = bus_we && (kind == RK_GCTL) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csel_q <= '0;
         psel_q <= '0;
         mask_q <= '0;
      end else if (soft_rst) begin
         csel_q <= '0;
         psel_q <= '0;
         mask_q <= '0;
      end else if (bus_we) begin
         if (kind == RK_CSEL) csel_q <= bus_wdata[CSEL_W-1:0];
         if (kind == RK_PSEL) psel_q <= bus_wdata[PSEL_W-1:0];
         if (kind == RK_MASK) mask_q <= bus_wdata[NCH-1:0];
      end
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_chan
         logic hit;
         assign hit = (csel_q == CSEL_W'(c));
         dmac_chan_bank #(
            .LEN_W    (LEN_W),
            .RST_CYC  (RST_CYC),
            .SET_WINS (SET_WINS)
         ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_rst  (soft_rst),
            .wr        (bus_we && hit && is_chan_kind(kind)),
            .kind      (kind),
            .wdata     (bus_wdata),
            .set_pulse (stat_set[c*6 +: 6]),
            .step      (desc_step[c]),
            .rdata     (chan_rd[c]),
            .on        (ch_on[c]),
            .tx        (ch_tx[c]),
            .idx       (desc_idx[c*LEN_W +: LEN_W]),
            .int_req   (chan_int[c])
         );
      end

      for (genvar p = 0; p < NPORT; p++) begin : g_port
         dmac_port_bank u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .wr       (bus_we && (kind == RK_PCTL) && (psel_q == PSEL_W'(p))),
            .wdata    (bus_wdata),
            .rdata    (port_rd[p])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      case (kind)
         RK_ID:   bus_rdata = ID_WORD;
         RK_CSEL: bus_rdata[CSEL_W-1:0] = csel_q;
         RK_PSEL: bus_rdata[PSEL_W-1:0] = psel_q;
         RK_MASK: bus_rdata[NCH-1:0]    = mask_q;
         RK_PCTL: begin
            for (int p = 0; p < NPORT; p++) begin
               if (psel_q == PSEL_W'(p)) bus_rdata = port_rd[p];
            end
         end
         RK_POLL, RK_CTRL, RK_BASE, RK_LEN, RK_STAT, RK_IE: begin
            for (int c = 0; c < NCH; c++) begin
               if (csel_q == CSEL_W'(c)) bus_rdata = chan_rd[c];
            end
         end
         default: bus_rdata = '0;
      endcase
   end

   assign irq = |(chan_int & mask_q);

endmodule

// File: rtl/dmac_rf_chk.sv
module dmac_rf_chk #(
   parameter int ADDR_W = 8,
   parameter int NCH    = 4,
   parameter int NPORT  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              irq
);

   logic [NCH-1:0] mask_sh;
   logic           known;

   always_comb begin
      known = 1'b0;
      if ((bus_addr >> 8) == '0) begin
         case (bus_addr[7:0])
            8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20,
            8'h24, 8'h28, 8'h2C, 8'h40, 8'h44, 8'hF4: known = 1'b1;
            default: known = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_sh <= '0;
      end else if (bus_we && (bus_addr == ADDR_W'(8'h10)) && bus_wdata[0]) begin
         mask_sh <= '0;
      end else if (bus_we && (bus_addr == ADDR_W'(8'hF4))) begin
         mask_sh <= bus_wdata[NCH-1:0];
      end
   end

   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !known |-> (bus_rdata == 32'd0));

   p_id_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8'h08)) |->
      (bus_rdata == {5'd0, 7'(NCH), 4'(NPORT), 16'd3}));

   p_gctl_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8'h10)) |-> (bus_rdata == 32'd0));

   p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_sh == '0) |-> !irq);

   p_irq_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && (mask_sh == '0)) |=> 1'b0);

endmodule

bind dmac_regfile dmac_rf_chk #(
   .ADDR_W (ADDR_W),
   .NCH    (NCH),
   .NPORT  (NPORT)
) u_chk (.*);

// File: tb/tb_dmac_regfile.sv
`timescale 1ns/1ps
module tb_dmac_regfile;

   localparam int NCH   = 4;
   localparam int LEN_W = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [7:0]         bus_addr = '0;
   logic               bus_we = 1'b0;
   logic [31:0]        bus_wdata = '0;
   logic [31:0]        bus_rdata;
   logic [NCH*6-1:0]   stat_set = '0;
   logic [NCH-1:0]     desc_step = '0;
   logic [NCH-1:0]     ch_on;
   logic [NCH-1:0]     ch_tx;
   logic [NCH*LEN_W-1:0] desc_idx;
   logic               irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dmac_regfile dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_set(stat_set),
      .desc_step(desc_step), .ch_on(ch_on), .ch_tx(ch_tx),
      .desc_idx(desc_idx), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(input int ch, input logic [5:0] bits);
      @(negedge clk);
      stat_set[ch*6 +: 6] = bits;
      @(negedge clk);
      stat_set = '0;
   endtask

   task automatic step(input int ch);
      @(negedge clk);
      desc_step[ch] = 1'b1;
      @(negedge clk);
      desc_step = '0;
   endtask

   task automatic t_reset_and_id;
      logic [31:0] d;
      rd(8'h08, d); check("R1 id word", d, 32'h00420003);
      wr(8'h08, 32'hFFFFFFFF);
      rd(8'h08, d); check("R1 id after write", d, 32'h00420003);
      rd(8'h18, d); check("R2 csel reset", d, 0);
      check("R3 ch_on reset", 32'(ch_on), 0);
      check("R6 irq reset", 32'(irq), 0);
   endtask

   task automatic t_banking;
      logic [31:0] d;
      wr(8'h18, 0); wr(8'h20, 32'hA0A0_1000);
      wr(8'h18, 1); wr(8'h20, 32'hB0B0_2000);
      wr(8'h18, 0); rd(8'h20, d); check("R2 base ch0", d, 32'hA0A0_1000);
      wr(8'h18, 1); rd(8'h20, d); check("R2 base ch1", d, 32'hB0B0_2000);
      wr(8'h18, 4); rd(8'h20, d); check("R2 base out of range", d, 0);
      wr(8'h20, 32'h1234_5678);
      wr(8'h18, 0); rd(8'h20, d); check("R2 ch0 untouched by oor write", d, 32'hA0A0_1000);
   endtask

   task automatic t_ctrl;
      logic [31:0] d;
      wr(8'h18, 2); wr(8'h1C, 32'h0002_0101);
      rd(8'h1C, d); check("R3 ctrl readback", d, 32'h0002_0101);
      check("R3 ch_on[2]", 32'(ch_on), 32'h4);
      check("R3 ch_tx[2]", 32'(ch_tx), 32'h4);
   endtask

   task automatic t_idx;
      wr(8'h18, 3); wr(8'h24, 3);
      for (int i = 0; i < 4; i++) step(3);
      check("R11 idx wraps at length", 32'(desc_idx[3*LEN_W +: LEN_W]), 1);
   endtask

   task automatic t_chan_reset;
      logic [31:0] d;
      wr(8'h18, 1); wr(8'h24, 5); wr(8'h1C, 1);
      step(1); step(1);
      pulse(1, 6'b000100);
      check("R11 idx ch1 before reset", 32'(desc_idx[LEN_W +: LEN_W]), 2);
      wr(8'h1C, 32'h3);
      rd(8'h1C, d); check("R4 busy right after write", d[1], 1);
      repeat (3) @(negedge clk);
      rd(8'h1C, d); check("R4 busy at 4th cycle", d[1], 1);
      @(negedge clk);
      rd(8'h1C, d); check("R4 ctrl after reset", d, 0);
      rd(8'h28, d); check("R4 status cleared", d, 0);
      check("R4 idx cleared", 32'(desc_idx[LEN_W +: LEN_W]), 0);
      check("R4 other channel keeps run", 32'(ch_on), 32'h4);
      check("R4 other channel idx kept", 32'(desc_idx[3*LEN_W +: LEN_W]), 1);
   endtask

   task automatic t_status;
      logic [31:0] d;
      wr(8'h18, 0);
      pulse(0, 6'b010100);
      rd(8'h28, d); check("R5 status set", d, 32'h28);
      wr(8'h28, 32'h08);
      rd(8'h28, d); check("R5 partial clear", d, 32'h20);
      wr(8'h28, 32'h7E);
      rd(8'h28, d); check("R5 full clear", d, 0);
      @(negedge clk);
      bus_addr = 8'h28; bus_wdata = 32'h7E; bus_we = 1'b1; stat_set[1:0] = 2'b10;
      @(negedge clk);
      bus_we = 1'b0; stat_set = '0;
      rd(8'h28, d); check("R5 set wins over clear", d, 32'h04);
      wr(8'h28, 32'h7E);
   endtask

   task automatic t_irq;
      wr(8'h18, 0); wr(8'h2C, 32'h08);
      pulse(0, 6'b000100);
      #1; check("R6 irq masked off", 32'(irq), 0);
      wr(8'hF4, 32'h2);
      #1; check("R6 irq wrong channel mask", 32'(irq), 0);
      wr(8'hF4, 32'h1);
      #1; check("R6 irq enabled", 32'(irq), 1);
      wr(8'h2C, 32'h10);
      #1; check("R6 irq event disabled", 32'(irq), 0);
      wr(8'h2C, 32'h08);
      wr(8'h28, 32'h08);
      #1; check("R6 irq after clear", 32'(irq), 0);
   endtask

   task automatic t_port_poll;
      logic [31:0] d;
      wr(8'h40, 0); wr(8'h44, 32'hFFFF_FFFF);
      wr(8'h40, 1); wr(8'h44, 32'h0000_002A);
      rd(8'h44, d); check("R7 port1 cfg", d, 32'h28);
      wr(8'h40, 0); rd(8'h44, d); check("R7 port0 cfg", d, 32'hF7C);
      wr(8'h18, 2); wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h14, d); check("R8 poll bits", d, 32'h8000_0040);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      wr(8'h30, 32'hDEAD_BEEF);
      rd(8'h30, d); check("R10 unmapped read", d, 0);
      rd(8'h1A, d); check("R10 unaligned read", d, 0);
      rd(8'h18, d); check("R10 csel untouched", d, 2);
   endtask

   task automatic t_soft_reset;
      logic [31:0] d;
      wr(8'h10, 32'h1);
      rd(8'h10, d); check("R9 gctl reads zero", d, 0);
      rd(8'h18, d); check("R9 csel cleared", d, 0);
      rd(8'hF4, d); check("R9 mask cleared", d, 0);
      rd(8'h20, d); check("R9 base cleared", d, 0);
      check("R9 run cleared", 32'(ch_on), 0);
      wr(8'h40, 0); rd(8'h44, d); check("R9 port cleared", d, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_and_id();
      t_banking();
      t_ctrl();
      t_idx();
      t_chan_reset();
      t_status();
      t_irq();
      t_port_poll();
      t_unmapped();
      t_soft_reset();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule